// File: doc/BRIEF.md
# Mode-Configurable Universal Decoder

This block decodes a small address into a set of eight select lines. A mode input chooses between two arrangements. In dual mode it works as two independent 2-to-4 decoders, half a driving lines 3..0 and half b driving lines 7..4. In wide mode the same eight lines form one 3-to-8 decoder addressed by the three half-a address bits.

Each half has a pair of active-low enables. In wide mode all four enables act together as one gate. Output polarity is set per half, and a common select inverts both halves. This lets the selected line stand high among lows, or low among highs. By default the decode is purely combinational. A parameter adds one clocked output stage with an asynchronous active-low reset.

Top module: `univ_decoder`

## Requirements
- R1: With `wide_mode_i`=0 and both half-a enables low, line `addr_a_i[1:0]` of lines 3..0 is the active line and lines 3..0 otherwise sit at the inactive level.
- R2: With `wide_mode_i`=0 and both half-b enables low, line 4+`addr_b_i` is the active line within lines 7..4.
- R3: In dual mode, if either enable of a half is high, all four lines of that half are inactive, and the other half's lines are unaffected.
- R4: With `wide_mode_i`=1 and all four enables low, line `addr_a_i[2:0]` is active and the other seven are inactive. `addr_b_i` has no effect.
- R5: With `wide_mode_i`=1, any enable bit high makes all eight lines inactive.
- R6: Lines 3..0 are active-high (active=1, inactive=0) when `pol_a_i` XOR `pol_common_i` is 1, and active-low (active=0, inactive=1) otherwise. Lines 7..4 follow the same rule with `pol_b_i`.
- R7: In dual mode `addr_a_i[2]` has no effect on any line.
- R8: With REGISTER_OUT=1, `line_o` shows the combinational result for the inputs present at the previous rising clock edge.
- R9: With REGISTER_OUT=1, `line_o` is all ones (inactive, active-low form) while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage and the checks |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_mode_i | input | 1 | 0: two 2-to-4 decoders, 1: one 3-to-8 decoder |
| addr_a_i | input | 3 | Half-a address; bit 2 is used only in wide mode |
| addr_b_i | input | 2 | Half-b address, used only in dual mode |
| en_a_ni | input | 2 | Half-a enables, active low |
| en_b_ni | input | 2 | Half-b enables, active low |
| pol_a_i | input | 1 | Polarity select for lines 3..0 |
| pol_b_i | input | 1 | Polarity select for lines 7..4 |
| pol_common_i | input | 1 | Polarity select applied to all lines |
| line_o | output | 8 | Decoded lines; bit n is line n |

## Verification
The bench sweeps all 8192 combinations of the 13 input bits, ordered so that the polarity bits vary fastest and the mode bit slowest. Sweeping the polarity bits separates the per-half select from the common select and shows that the two halves are inverted independently. Sweeping every enable pattern in both modes shows how each half is gated on its own in dual mode and how all four enables gate together in wide mode. Sweeping the unused address bits (bit 2 of the half-a address in dual mode, the half-b address in wide mode) shows that they are ignored. A combinational instance and a registered instance run side by side, so the registered one is also checked for its one-cycle delay and its reset level.

// File: rtl/univ_decoder_pkg.sv
package univ_decoder_pkg;
  typedef enum logic {
    MODE_DUAL = 1'b0,
    MODE_WIDE = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/univ_dec_route.sv
// Steers address and enables to the two halves according to the mode.
module univ_dec_route
  import univ_decoder_pkg::*;
#(
  parameter int unsigned HALF_AW = 2,
  parameter int unsigned EN_W    = 2
) (
  input  dec_mode_e            mode_i,
  input  logic [HALF_AW:0]     addr_a_i,
  input  logic [HALF_AW-1:0]   addr_b_i,
  input  logic [EN_W-1:0]      en_a_ni,
  input  logic [EN_W-1:0]      en_b_ni,
  output logic                 go_a_o,
  output logic                 go_b_o,
  output logic [HALF_AW-1:0]   idx_a_o,
  output logic [HALF_AW-1:0]   idx_b_o
);
  logic ok_a, ok_b, ok_all;

  assign ok_a   = ~|en_a_ni;
  assign ok_b   = ~|en_b_ni;
  assign ok_all = ok_a & ok_b;

  always_comb begin
    idx_a_o = addr_a_i[HALF_AW-1:0];
    if (mode_i == MODE_WIDE) begin
      // top address bit picks the half, low bits shared
      go_a_o  = ok_all & ~addr_a_i[HALF_AW];
      go_b_o  = ok_all &  addr_a_i[HALF_AW];
      idx_b_o = addr_a_i[HALF_AW-1:0];
    end else begin
      go_a_o  = ok_a;
      go_b_o  = ok_b;
      idx_b_o = addr_b_i;
    end
  end
endmodule

// File: rtl/univ_dec_half.sv
// One-hot decode of a half address, gated by go_i.
module univ_dec_half #(
  parameter int unsigned AW = 2,
  localparam int unsigned LINES = 1 << AW
) (
  input  logic          go_i,
  input  logic [AW-1:0] idx_i,
  output logic [LINES-1:0] hit_o
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    assign hit_o[n] = go_i & (idx_i == AW'(n));
  end
endmodule

// File: rtl/univ_dec_out.sv
// Polarity application and optional output register.
module univ_dec_out #(
  parameter int unsigned HALF_LINES   = 4,
  parameter bit          REGISTER_OUT = 1'b0,
  localparam int unsigned LINES = 2 * HALF_LINES
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [HALF_LINES-1:0] hit_a_i,
  input  logic [HALF_LINES-1:0] hit_b_i,
  input  logic                  hi_a_i,
  input  logic                  hi_b_i,
  output logic [LINES-1:0]      line_o
);
  logic [LINES-1:0] line_d;

  assign line_d = {hit_b_i ^ {HALF_LINES{~hi_b_i}}, hit_a_i ^ {HALF_LINES{~hi_a_i}}};

  if (REGISTER_OUT) begin : g_reg
    logic [HALF_LINES-1:0] hit_a_q, hit_b_q;
    logic                  hi_a_q, hi_b_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_a_q <= '0;
        hit_b_q <= '0;
        hi_a_q  <= 1'b0;
        hi_b_q  <= 1'b0;
      end else begin
        hit_a_q <= hit_a_i;
        hit_b_q <= hit_b_i;
        hi_a_q  <= hi_a_i;
        hi_b_q  <= hi_b_i;
      end
    end

    assign line_o = {hit_b_q ^ {HALF_LINES{~hi_b_q}}, hit_a_q ^ {HALF_LINES{~hi_a_q}}};

    assert_reg_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> line_o == $past(line_d));
  end else begin : g_comb
    assign line_o = line_d;
  end
endmodule

// File: rtl/univ_decoder.sv
module univ_decoder
  import univ_decoder_pkg::*;
#(
  parameter int unsigned HALF_AW      = 2,
  parameter int unsigned EN_W         = 2,
  parameter bit          REGISTER_OUT = 1'b0,
  localparam int unsigned HALF_LINES = 1 << HALF_AW,
  localparam int unsigned LINES      = 2 * HALF_LINES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wide_mode_i,
  input  logic [HALF_AW:0]   addr_a_i,
  input  logic [HALF_AW-1:0] addr_b_i,
  input  logic [EN_W-1:0]    en_a_ni,
  input  logic [EN_W-1:0]    en_b_ni,
  input  logic               pol_a_i,
  input  logic               pol_b_i,
  input  logic               pol_common_i,
  output logic [LINES-1:0]   line_o
);
  dec_mode_e                 mode;
  logic                      go_a, go_b;
  logic [HALF_AW-1:0]        idx_a, idx_b;
  logic [HALF_LINES-1:0]     hit_a, hit_b;
  logic                      hi_a, hi_b;

  assign mode = dec_mode_e'(wide_mode_i);
  // effective polarity: 1 = selected line high
  assign hi_a = pol_a_i ^ pol_common_i;
  assign hi_b = pol_b_i ^ pol_common_i;

  univ_dec_route #(.HALF_AW(HALF_AW), .EN_W(EN_W)) i_route (
    .mode_i   (mode),
    .addr_a_i (addr_a_i),
    .addr_b_i (addr_b_i),
    .en_a_ni  (en_a_ni),
    .en_b_ni  (en_b_ni),
    .go_a_o   (go_a),
    .go_b_o   (go_b),
    .idx_a_o  (idx_a),
    .idx_b_o  (idx_b)
  );

  univ_dec_half #(.AW(HALF_AW)) i_half_a (.go_i(go_a), .idx_i(idx_a), .hit_o(hit_a));
  univ_dec_half #(.AW(HALF_AW)) i_half_b (.go_i(go_b), .idx_i(idx_b), .hit_o(hit_b));

  univ_dec_out #(.HALF_LINES(HALF_LINES), .REGISTER_OUT(REGISTER_OUT)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_a_i (hit_a),
    .hit_b_i (hit_b),
    .hi_a_i  (hi_a),
    .hi_b_i  (hi_b),
    .line_o  (line_o)
  );

  assert_half_a_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_a));
  assert_half_b_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_b));
  assert_dual_gate_a_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_mode_i && (|en_a_ni)) |-> (hit_a == '0));
  assert_wide_one_half_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_mode_i |-> !((|hit_a) && (|hit_b)));
  assert_wide_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_mode_i && ((|en_a_ni) || (|en_b_ni))) |-> ((hit_a == '0) && (hit_b == '0)));
endmodule

// File: tb/test_univ_decoder.sv
`timescale 1ns/1ps
module test_univ_decoder;
  localparam real PERIOD = 8.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wide_mode;
  logic [2:0] addr_a;
  logic [1:0] addr_b, en_a_n, en_b_n;
  logic       pol_a, pol_b, pol_c;
  logic [7:0] line_comb, line_reg;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] reg_q[$];

  always #(PERIOD/2) clk = ~clk;

  univ_decoder i_univ_decoder (
    .clk_i(clk), .rst_ni(rst_n), .wide_mode_i(wide_mode), .addr_a_i(addr_a),
    .addr_b_i(addr_b), .en_a_ni(en_a_n), .en_b_ni(en_b_n), .pol_a_i(pol_a),
    .pol_b_i(pol_b), .pol_common_i(pol_c), .line_o(line_comb)
  );

  univ_decoder #(.REGISTER_OUT(1'b1)) i_univ_decoder_reg (
    .clk_i(clk), .rst_ni(rst_n), .wide_mode_i(wide_mode), .addr_a_i(addr_a),
    .addr_b_i(addr_b), .en_a_ni(en_a_n), .en_b_ni(en_b_n), .pol_a_i(pol_a),
    .pol_b_i(pol_b), .pol_common_i(pol_c), .line_o(line_reg)
  );

  // behavioural truth-table model; v = {mode, aa[2:0], ab[1:0], ea[1:0], eb[1:0], pa, pb, pc}
  function automatic logic [7:0] model(input logic [12:0] v);
    int sel_a = -1;
    int sel_b = -1;
    logic [7:0] r;
    if (v[12]) begin
      if (v[6:3] == 4'b0000) begin
        if (v[11]) sel_b = int'(v[10:9]); else sel_a = int'(v[10:9]);
      end
    end else begin
      if (v[6:5] == 2'b00) sel_a = int'(v[10:9]);
      if (v[4:3] == 2'b00) sel_b = int'(v[8:7]);
    end
    for (int n = 0; n < 4; n++) begin
      r[n]   = ((n == sel_a) == (v[2] != v[0]));
      r[n+4] = ((n == sel_b) == (v[1] != v[0]));
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [12:0] v);
    if (v[12]) return (v[6:3] != 0) ? "R5/R6" : "R4/R6";
    if (v[6:3] != 0) return "R3/R6";
    if (v[11]) return "R7/R6";
    return "R1/R2/R6";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [12:0] v);
    {wide_mode, addr_a, addr_b, en_a_n, en_b_n, pol_a, pol_b, pol_c} = v;
  endtask

  initial begin
    apply(13'h0);
    // R9: registered output idle during reset
    repeat (3) begin
      @(negedge clk);
      check("R9", line_reg, 8'hFF);
    end
    apply(13'h1555);
    @(negedge clk);
    check("R9", line_reg, 8'hFF);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 8192; i++) begin
      logic [12:0] v;
      v = 13'(i);
      @(posedge clk);
      #1 apply(v);
      @(negedge clk);
      check(tag_of(v), line_comb, model(v));
      if (reg_q.size() > 0) check("R8", line_reg, reg_q.pop_front());
      reg_q.push_back(model(v));
    end
    @(posedge clk);
    @(negedge clk);
    check("R8", line_reg, reg_q.pop_front());
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule